// File: doc/BRIEF.md
# Byte Inversion Decision Encoder

This block decides whether a data byte should be sent inverted so that a bus never carries more ones than zeros. It is purely combinational. A flag goes high when at least half of the input bits are set. When the flag is high the data output is the bitwise complement of the input. When the flag is low the data output equals the input. The flag is driven out beside the data so that a receiver can undo the inversion.

The threshold is never computed by adding bits together. Each half of the word is reduced by a tree of two-input merges into a set of "at least k bits set" flags. The two sets of half flags are then paired in a complementary way: at least k in one half together with at least T-k in the other. Because every merge stage is one AND level followed by one OR level, the logic depth grows with the logarithm of the width.

A parameter selects a second, equivalent form. This form counts zeros on the complemented input, tests for "at least half plus one zeros", and inverts that answer. Both forms give the same function.

Top module: `dbi_encoder`

## Requirements
- R1: `inv_o` is 1 exactly when the number of ones in `data_i` is at least DATA_W/2 (4 for the default width of 8), and 0 otherwise.
- R2: At the boundary of exactly four ones, `inv_o` is 1 and `data_o` also has exactly four ones.
- R3: With exactly three ones `inv_o` is 0. With exactly five ones `inv_o` is 1.
- R4: When `inv_o` is 1, `data_o` equals the bitwise complement of `data_i`.
- R5: When `inv_o` is 0, `data_o` equals `data_i` bit for bit.
- R6: For every input, `data_o` carries at most DATA_W/2 ones.
- R7: With ZERO_FORM=1 (zero-counting form), `inv_o` and `data_o` match the ZERO_FORM=0 form for every input.
- R8: The outputs depend only on the present value of `data_i`. All 256 values of the default width give the results of R1, R4 and R5, whatever the order in which they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Data word to be encoded |
| data_o | output | DATA_W | Encoded word: the input, or its complement when inverted |
| inv_o | output | 1 | High when `data_o` is the inverted input |

## Verification
The sharpest corners are the weights three, four and five. A merge that drops one of the complementary pairs would miss some four-one patterns, for example all four ones in one half, or two ones in each half. An off-by-one threshold would flip every weight-three or weight-four word. The all-zero and all-one words exercise the terms that take their value from a single half. A stale ordering dependency, or a zero form with the wrong threshold, shows up in the exhaustive sweeps, which run both ascending and descending.

// File: rtl/dbi_thr_pkg.sv
package dbi_thr_pkg;
  // Threshold at which a word of width w is sent inverted
  function automatic int inv_threshold(input int w);
    return w / 2;
  endfunction

  // Zero-count threshold used by the complementary form
  function automatic int zero_threshold(input int w);
    return w / 2 + 1;
  endfunction
endpackage

// File: rtl/thr_merge.sv
// Merges the at-least-k flags of two groups of W bits each into
// at-least-k flags for the joined 2W-bit group. Each flag is one AND level and one OR level.
module thr_merge #(
  parameter int W = 1
) (
  input  logic [W:1]   a_ge,
  input  logic [W:1]   b_ge,
  output logic [2*W:1] y_ge
);
  localparam int OW = 2 * W;

  logic [W:0] ax;
  logic [W:0] bx;

  assign ax = {a_ge, 1'b1};
  assign bx = {b_ge, 1'b1};

  always_comb begin
    y_ge = '0;
    for (int k = 1; k <= OW; k++) begin
      for (int i = 0; i <= W; i++) begin
        if ((k - i >= 0) && (k - i <= W)) begin
          y_ge[k] = y_ge[k] | (ax[i] & bx[k-i]);
        end
      end
    end
  end
endmodule

// File: rtl/thr_count_flags.sv
// Recursive tree: it gives the at-least-k flags (k = 1..W) of a W-bit group.
// W must be a power of two.
module thr_count_flags #(
  parameter int W = 4
) (
  input  logic [W-1:0] bits_i,
  output logic [W:1]   ge_o
);
  localparam int HW = W / 2;

  generate
    if (W == 1) begin : g_leaf
      assign ge_o[1] = bits_i[0];
    end else begin : g_node
      logic [HW:1] lo_ge;
      logic [HW:1] hi_ge;

      thr_count_flags #(.W(HW)) lo_i (
        .bits_i(bits_i[HW-1:0]),
        .ge_o  (lo_ge)
      );
      thr_count_flags #(.W(HW)) hi_i (
        .bits_i(bits_i[W-1:HW]),
        .ge_o  (hi_ge)
      );
      thr_merge #(.W(HW)) mrg_i (
        .a_ge(lo_ge),
        .b_ge(hi_ge),
        .y_ge(ge_o)
      );
    end
  endgenerate
endmodule

// File: rtl/thr_pair_combine.sv
// Decides "at least TH set" across two halves of H bits each from their flag sets.
// It pairs at-least-k of one half with at-least-(TH-k) of the other.
module thr_pair_combine #(
  parameter int H  = 4,
  parameter int TH = 4
) (
  input  logic [H:1] lo_ge,
  input  logic [H:1] hi_ge,
  output logic       hit_o
);
  localparam int KLO = (TH > H) ? TH - H : 0;
  localparam int KHI = (TH < H) ? TH : H;

  logic [H:0] lx;
  logic [H:0] hx;

  assign lx = {lo_ge, 1'b1};
  assign hx = {hi_ge, 1'b1};

  always_comb begin
    hit_o = 1'b0;
    for (int k = KLO; k <= KHI; k++) begin
      hit_o = hit_o | (lx[k] & hx[TH-k]);
    end
  end
endmodule

// File: rtl/dbi_encoder.sv
module dbi_encoder #(
  parameter int DATA_W    = 8,
  parameter bit ZERO_FORM = 1'b0
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              inv_o
);
  import dbi_thr_pkg::*;

  localparam int HALF  = DATA_W / 2;
  localparam int TH_1  = inv_threshold(DATA_W);
  localparam int TH_0  = zero_threshold(DATA_W);

  logic [DATA_W-1:0] probe;
  logic [HALF:1]     lo_ge;
  logic [HALF:1]     hi_ge;
  logic              hit;
  logic              flag;

  generate
    if (ZERO_FORM) begin : g_zero_in
      assign probe = ~data_i;
    end else begin : g_one_in
      assign probe = data_i;
    end
  endgenerate

  thr_count_flags #(.W(HALF)) lo_cnt_i (
    .bits_i(probe[HALF-1:0]),
    .ge_o  (lo_ge)
  );

  thr_count_flags #(.W(HALF)) hi_cnt_i (
    .bits_i(probe[DATA_W-1:HALF]),
    .ge_o  (hi_ge)
  );

  generate
    if (ZERO_FORM) begin : g_zero_dec
      thr_pair_combine #(.H(HALF), .TH(TH_0)) comb_i (
        .lo_ge(lo_ge),
        .hi_ge(hi_ge),
        .hit_o(hit)
      );
      assign flag = ~hit;
    end else begin : g_one_dec
      thr_pair_combine #(.H(HALF), .TH(TH_1)) comb_i (
        .lo_ge(lo_ge),
        .hi_ge(hi_ge),
        .hit_o(hit)
      );
      assign flag = hit;
    end
  endgenerate

  assign inv_o  = flag;
  assign data_o = data_i ^ {DATA_W{flag}};
endmodule

// File: rtl/dbi_encoder_chk.sv
module dbi_encoder_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              inv_o
);
  always_comb begin
    // R1
    flag_thresh_chk: assert (inv_o == ($countones(data_i) >= DATA_W / 2));
    // R4
    invert_path_chk: assert (!inv_o || (data_o == ~data_i));
    // R5
    pass_path_chk: assert (inv_o || (data_o == data_i));
    // R6
    out_weight_chk: assert ($countones(data_o) <= DATA_W / 2);
    // R2
    boundary_chk: assert (($countones(data_i) != DATA_W / 2) ||
                          ($countones(data_o) == DATA_W / 2));
  end
endmodule

bind dbi_encoder dbi_encoder_chk #(.DATA_W(DATA_W)) chk_i (
  .data_i(data_i),
  .data_o(data_o),
  .inv_o (inv_o)
);

// File: tb/dbi_encoder_tb_top.sv
module dbi_encoder_tb_top;
  localparam int DW = 8;

  logic          clk;
  logic [DW-1:0] data_i;
  logic [DW-1:0] data_o;
  logic          inv_o;
  logic [DW-1:0] zdata_o;
  logic          zinv_o;
  int            n_cmp;
  int            n_bad;
  bit            done;

  dbi_encoder #(.DATA_W(DW), .ZERO_FORM(1'b0)) dut_i (
    .data_i(data_i), .data_o(data_o), .inv_o(inv_o));

  dbi_encoder #(.DATA_W(DW), .ZERO_FORM(1'b1)) dut_z_i (
    .data_i(data_i), .data_o(zdata_o), .inv_o(zinv_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s data=%h actual=%h expected=%h", req, data_i, act, exp);
    end
  endtask

  task automatic apply(input logic [DW-1:0] v);
    @(posedge clk);
    data_i = v;
    @(negedge clk);
  endtask

  task automatic check_all(input logic [DW-1:0] v);
    logic          e_inv;
    logic [DW-1:0] e_dat;
    e_inv = ($countones(v) >= DW / 2);
    e_dat = e_inv ? ~v : v;
    check("R1", {8'h0, inv_o}, {8'h0, e_inv});
    if (e_inv) check("R4", {1'b0, data_o}, {1'b0, e_dat});
    else       check("R5", {1'b0, data_o}, {1'b0, e_dat});
    check("R6", {8'h0, ($countones(data_o) <= DW / 2)}, 9'h1);
    check("R7", {zinv_o, zdata_o}, {inv_o, data_o});
  endtask

  task automatic t_extremes;
    apply(8'h00);
    check("R5", {inv_o, data_o}, {1'b0, 8'h00});
    apply(8'hFF);
    check("R4", {inv_o, data_o}, {1'b1, 8'h00});
  endtask

  task automatic t_boundary;
    // R2: four ones in several shapes
    logic [DW-1:0] pats [4] = '{8'h0F, 8'hF0, 8'h33, 8'h81 | 8'h18};
    foreach (pats[i]) begin
      apply(pats[i]);
      check("R2", {inv_o, data_o}, {1'b1, ~pats[i]});
      check("R2", {5'h0, 4'($countones(data_o))}, 9'd4);
    end
    // R3: three and five ones
    apply(8'h07); check("R3", {8'h0, inv_o}, 9'h0);
    apply(8'hE0); check("R3", {8'h0, inv_o}, 9'h0);
    apply(8'h1F); check("R3", {8'h0, inv_o}, 9'h1);
    apply(8'hF1); check("R3", {8'h0, inv_o}, 9'h1);
  endtask

  task automatic t_sweep_up;
    for (int v = 0; v < 256; v++) begin
      apply(DW'(v));
      check_all(DW'(v));
    end
  endtask

  task automatic t_sweep_down;
    // R8: reverse order must give identical results
    for (int v = 255; v >= 0; v--) begin
      apply(DW'(v));
      check_all(DW'(v));
    end
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    data_i = '0;
    @(negedge clk);
    check("R1", {inv_o, data_o}, {1'b0, 8'h00});
    t_extremes();
    t_boundary();
    t_sweep_up();
    t_sweep_down();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule